// File: doc/BRIEF.md
# Nonvolatile Store Access Control Register

This block is an eight-bit control and status register. It sequences read, write and row-erase operations on an on-chip nonvolatile store. Software writes the register over a single-register bus with a write strobe and an eight-bit data word, and can read back its current value at any time. The block picks a target space (data store, program flash or configuration space) and latches the address pointer. It launches an operation on the backend with a one-cycle start pulse. For writes and erases it then waits for the backend's completion pulse.

Software can only set the request bits, and hardware clears them. Reads are refused for the flash and configuration targets. While a write or erase is in flight, new requests are ignored, and later changes to the selects do not alter the running operation.

The block has two reset levels. The power-on reset (asynchronous, active low) clears every bit. The operational reset (synchronous, active low) drops the request bits and write enable. If it arrives during a write, it sets a sticky error flag and leaves the select bits in place, so the failed target can be traced.

Top module: `nvm_ctrl_reg`

## Requirements
- R1: The register reads, from bit 7 down to bit 0: flash select, configuration select, a reserved bit that always reads 0, erase enable, error flag, write enable, write start, read start. A software write loads bits 7, 6, 4, 3 and 2 from the data word.
- R2: The target driven on `be_tgt` when an operation is accepted is 2'b10 when the configuration select is 1, whatever the flash select is. Otherwise it is 2'b01 when the flash select is 1, and 2'b00 for the data store.
- R3: Write start is set only by a write that has data bit 1 and data bit 2 (write enable) both at 1. Writing 0 to bit 1 never clears it.
- R4: Read start is set by a write that meets all of these conditions: data bit 0 is 1, data bits 7 and 6 are both 0, the block is not busy, and the same write does not start a write. Read start then stays high for exactly one cycle, and `be_rd` is high in that same cycle.
- R5: In the cycle after a write start is accepted, the block issues a one-cycle pulse. The pulse is `be_erase` if data bit 4 was 1, and `be_wr` otherwise. `be_addr` holds the pointer value sampled when the request was accepted. No two start pulses are ever high together.
- R6: While write start is 1, the block ignores further attempts to set write start or read start, and it ignores writes to erase enable. Writes to the select bits still change the register but leave `be_tgt` unchanged.
- R7: A `be_done` pulse while write start is 1 clears write start and the error flag, and also clears erase enable if the operation was an erase. A `be_done` pulse while idle changes nothing.
- R8: An operational reset while write start is 1 sets the error flag. It clears write enable, write start and read start, and keeps the flash select, configuration select and erase enable. A later `be_done` changes nothing.
- R9: An operational reset while idle clears write enable and leaves the error flag and all other bits unchanged.
- R10: After power-on reset the register reads 0x00 and no start pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| oprst_n | input | 1 | Operational reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| addr_in | input | AW | Address pointer from the system |
| be_rd | output | 1 | One-cycle read start to the backend |
| be_wr | output | 1 | One-cycle write start to the backend |
| be_erase | output | 1 | One-cycle row-erase start to the backend |
| be_tgt | output | 2 | Target space of the current operation |
| be_addr | output | AW | Address latched at acceptance |
| be_done | input | 1 | Backend completion pulse |

## Verification
The bench builds the block with a four-bit address pointer. This lets each sweep iteration load a distinct pointer value and check it on `be_addr`. The backend completion latency is set to five cycles, which leaves a window for bus writes and an operational reset to land while the block is busy. With only eight register bits, the bench sweeps every possible write value from the reset state. That covers each combination of selects, enable and request bits, including the read interlock and the reserved bit.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  // bit positions inside the control register
  localparam int B_MSEL  = 7;
  localparam int B_CSEL  = 6;
  localparam int B_RSVD  = 5;
  localparam int B_ERASE = 4;
  localparam int B_WERR  = 3;
  localparam int B_WEN   = 2;
  localparam int B_WST   = 1;
  localparam int B_RST   = 0;
  localparam int REG_W   = 8;

  typedef enum logic [1:0] {
    TGT_DATA  = 2'b00,
    TGT_FLASH = 2'b01,
    TGT_CFG   = 2'b10
  } nvm_tgt_e;

  // configuration select overrides the flash select
  function automatic nvm_tgt_e tgt_of(input logic msel, input logic csel);
    if (csel)      return TGT_CFG;
    else if (msel) return TGT_FLASH;
    else           return TGT_DATA;
  endfunction

  // reads are allowed only for the data store
  function automatic logic rd_allowed(input logic msel, input logic csel);
    return !msel && !csel;
  endfunction

endpackage

// File: rtl/nvm_cfg_bits.sv
module nvm_cfg_bits (
  input  logic clk,
  input  logic por_n,
  input  logic oprst_n,
  input  logic we,
  input  logic wd_msel,
  input  logic wd_csel,
  input  logic wd_erase,
  input  logic wd_werr,
  input  logic wd_wen,
  input  logic busy,
  input  logic done_evt,
  input  logic op_erase,
  output logic msel,
  output logic csel,
  output logic erase_en,
  output logic werr,
  output logic wen
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      msel     <= 1'b0;
      csel     <= 1'b0;
      erase_en <= 1'b0;
      werr     <= 1'b0;
      wen      <= 1'b0;
    end else if (!oprst_n) begin
      wen <= 1'b0;
      if (busy) werr <= 1'b1;
    end else begin
      if (we) begin
        msel <= wd_msel;
        csel <= wd_csel;
        wen  <= wd_wen;
        werr <= wd_werr;
        if (!busy) erase_en <= wd_erase;
      end
      if (done_evt) begin
        werr <= 1'b0;
        if (op_erase) erase_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
  import nvm_ctrl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          oprst_n,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          done_evt,
  input  logic          wd_msel,
  input  logic          wd_csel,
  input  logic          wd_erase,
  input  logic [AW-1:0] addr_in,
  output logic          wstart,
  output logic          rstart,
  output logic          issue,
  output logic          op_erase,
  output nvm_tgt_e      tgt,
  output logic [AW-1:0] addr_lat
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wstart   <= 1'b0;
      rstart   <= 1'b0;
      issue    <= 1'b0;
      op_erase <= 1'b0;
      tgt      <= TGT_DATA;
      addr_lat <= '0;
    end else if (!oprst_n) begin
      wstart <= 1'b0;
      rstart <= 1'b0;
      issue  <= 1'b0;
    end else begin
      rstart <= rd_acc;
      issue  <= wr_acc;
      if (wr_acc)        wstart <= 1'b1;
      else if (done_evt) wstart <= 1'b0;
      if (wr_acc || rd_acc) begin
        tgt      <= tgt_of(wd_msel, wd_csel);
        addr_lat <= addr_in;
        op_erase <= wr_acc && wd_erase;
      end
    end
  end

endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_ctrl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          oprst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [AW-1:0] addr_in,
  output logic          be_rd,
  output logic          be_wr,
  output logic          be_erase,
  output logic [1:0]    be_tgt,
  output logic [AW-1:0] be_addr,
  input  logic          be_done
);

  logic     msel, csel, erase_en, werr, wen;
  logic     wstart, rstart, issue, op_is_erase;
  logic     busy, wr_acc, rd_acc, done_evt;
  nvm_tgt_e tgt;

  // named internal events, also seen by the checker
  assign busy     = wstart;
  assign wr_acc   = reg_we && oprst_n && !busy
                    && reg_wdata[B_WST] && reg_wdata[B_WEN];
  assign rd_acc   = reg_we && oprst_n && !busy && !wr_acc && reg_wdata[B_RST]
                    && rd_allowed(reg_wdata[B_MSEL], reg_wdata[B_CSEL]);
  assign done_evt = be_done && busy && oprst_n;

  nvm_cfg_bits u_bits (
    .clk      (clk),
    .por_n    (por_n),
    .oprst_n  (oprst_n),
    .we       (reg_we),
    .wd_msel  (reg_wdata[B_MSEL]),
    .wd_csel  (reg_wdata[B_CSEL]),
    .wd_erase (reg_wdata[B_ERASE]),
    .wd_werr  (reg_wdata[B_WERR]),
    .wd_wen   (reg_wdata[B_WEN]),
    .busy     (busy),
    .done_evt (done_evt),
    .op_erase (op_is_erase),
    .msel     (msel),
    .csel     (csel),
    .erase_en (erase_en),
    .werr     (werr),
    .wen      (wen)
  );

  nvm_op_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .por_n    (por_n),
    .oprst_n  (oprst_n),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .done_evt (done_evt),
    .wd_msel  (reg_wdata[B_MSEL]),
    .wd_csel  (reg_wdata[B_CSEL]),
    .wd_erase (reg_wdata[B_ERASE]),
    .addr_in  (addr_in),
    .wstart   (wstart),
    .rstart   (rstart),
    .issue    (issue),
    .op_erase (op_is_erase),
    .tgt      (tgt),
    .addr_lat (be_addr)
  );

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_MSEL]  = msel;
    reg_rdata[B_CSEL]  = csel;
    reg_rdata[B_RSVD]  = 1'b0;
    reg_rdata[B_ERASE] = erase_en;
    reg_rdata[B_WERR]  = werr;
    reg_rdata[B_WEN]   = wen;
    reg_rdata[B_WST]   = wstart;
    reg_rdata[B_RST]   = rstart;
  end

  assign be_rd    = rstart;
  assign be_wr    = issue && !op_is_erase;
  assign be_erase = issue && op_is_erase;
  assign be_tgt   = tgt;

endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       oprst_n,
  input logic       be_done,
  input logic [7:0] reg_rdata,
  input logic       be_rd,
  input logic       be_wr,
  input logic       be_erase,
  input logic       done_evt,
  input logic       op_is_erase
);

  assert_wstart_needs_wen_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg_rdata[1]) |-> reg_rdata[2]);

  assert_rd_one_cycle_R4: assert property (@(posedge clk) disable iff (!por_n)
    reg_rdata[0] |=> !reg_rdata[0]);

  assert_rd_target_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg_rdata[0]) |-> (!reg_rdata[7] && !reg_rdata[6] && be_rd));

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({be_rd, be_wr, be_erase}));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[1] && !be_done && oprst_n) |=> reg_rdata[1]);

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    done_evt |=> (!reg_rdata[1] && !reg_rdata[3]));

  assert_erase_clear_R7: assert property (@(posedge clk) disable iff (!por_n)
    (done_evt && op_is_erase) |=> !reg_rdata[4]);

  assert_abort_R8: assert property (@(posedge clk) disable iff (!por_n)
    (reg_rdata[1] && !oprst_n) |=>
      (reg_rdata[3] && !reg_rdata[2] && !reg_rdata[1]
       && $stable(reg_rdata[7]) && $stable(reg_rdata[6])));

endmodule

bind nvm_ctrl_reg nvm_ctrl_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .oprst_n     (oprst_n),
  .be_done     (be_done),
  .reg_rdata   (reg_rdata),
  .be_rd       (be_rd),
  .be_wr       (be_wr),
  .be_erase    (be_erase),
  .done_evt    (done_evt),
  .op_is_erase (op_is_erase)
);

// File: tb/sim_nvm_ctrl_reg.sv
module sim_nvm_ctrl_reg;
  localparam int AW       = 4;
  localparam int DONE_LAT = 5;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          oprst_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] addr_in = '0;
  logic          be_rd, be_wr, be_erase, be_done;
  logic [1:0]    be_tgt;
  logic [AW-1:0] be_addr;

  int checks = 0;
  int fails  = 0;

  initial be_done = 1'b0;
  always #4 clk = ~clk;

  nvm_ctrl_reg #(.AW(AW)) u0 (
    .clk(clk), .por_n(por_n), .oprst_n(oprst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_in(addr_in),
    .be_rd(be_rd), .be_wr(be_wr), .be_erase(be_erase), .be_tgt(be_tgt),
    .be_addr(be_addr), .be_done(be_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); be_done = 1'b1;
    @(negedge clk); be_done = 1'b0;
  endtask

  task automatic op_reset();
    @(negedge clk); oprst_n = 1'b0;
    @(negedge clk); oprst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R10: power-on state
    do_por();
    chk("R10 reg after por", reg_rdata, 8'h00);
    chk("R10 no pulses", {be_rd, be_wr, be_erase}, 3'b000);

    // R1..R5: sweep every write value from the reset state
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      logic ws, rs;
      logic [1:0] tg;
      w  = v[7:0];
      ws = w[1] & w[2];
      rs = w[0] & !w[7] & !w[6] & !ws;
      tg = w[6] ? 2'b10 : (w[7] ? 2'b01 : 2'b00);
      do_por();
      addr_in = w[3:0];
      bus_wr(w);
      chk("R1 R3 R4 reg image", reg_rdata,
          {w[7], w[6], 1'b0, w[4], w[3], w[2], ws, rs});
      chk("R4 R5 start pulses", {be_rd, be_wr, be_erase},
          {rs, ws & !w[4], ws & w[4]});
      if (ws || rs) begin
        chk("R2 target", be_tgt, tg);
        chk("R5 address", be_addr, w[3:0]);
      end
      @(negedge clk);
      chk("R4 R5 pulses end", {reg_rdata[0], be_rd, be_wr, be_erase}, 4'b0000);
      chk("R3 busy holds", reg_rdata[1], ws);
    end

    // R6 R3 R7: busy behaviour and completion
    do_por();
    bus_wr(8'h0E);
    chk("R3 write start", reg_rdata, 8'h0E);
    bus_wr(8'hDF);
    chk("R6 requests and erase ignored while busy", reg_rdata, 8'hCE);
    chk("R6 target unchanged", be_tgt, 2'b00);
    chk("R6 no read pulse", {be_rd, be_wr, be_erase}, 3'b000);
    bus_wr(8'h0C);
    chk("R3 writing 0 to write start", reg_rdata, 8'h0E);
    repeat (DONE_LAT) @(negedge clk);
    pulse_done();
    chk("R7 completion clears start and error", reg_rdata, 8'h04);
    pulse_done();
    chk("R7 done while idle ignored", reg_rdata, 8'h04);

    // R5 R7: flash row erase
    do_por();
    addr_in = 4'hA;
    bus_wr(8'h96);
    chk("R5 erase pulse", {be_rd, be_wr, be_erase}, 3'b001);
    chk("R2 flash target", be_tgt, 2'b01);
    chk("R5 erase address", be_addr, 4'hA);
    addr_in = 4'h3;
    repeat (DONE_LAT) @(negedge clk);
    chk("R5 address held", be_addr, 4'hA);
    pulse_done();
    chk("R7 erase enable cleared", reg_rdata, 8'h84);

    // R8: abort during a write
    do_por();
    bus_wr(8'hD6);
    chk("R2 config overrides", be_tgt, 2'b10);
    repeat (2) @(negedge clk);
    op_reset();
    chk("R8 abort image", reg_rdata, 8'hD8);
    pulse_done();
    chk("R8 late done ignored", reg_rdata, 8'hD8);

    // R9: operational reset while idle
    bus_wr(8'h0C);
    chk("R9 setup", reg_rdata, 8'h0C);
    op_reset();
    chk("R9 idle reset keeps error", reg_rdata, 8'h08);

    // R10: power-on clears everything
    do_por();
    chk("R10 final por", reg_rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule